// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block collects the events raised by the transfer engine and data buffer of a host-controlled I2C master. Each event arrives as a one-cycle pulse and sets a sticky status flag. A small enable mask selects which of the low status flags may raise the single interrupt line. Two DMA request lines follow the receive-ready and transmit-ready flags when their DMA enables are set. Bus signalling and the data path sit outside this block.

The host reaches the block through a simple register port: word index 0 is a constant revision (0x11), 1 is the interrupt enable, 2 is the status, 3 is the vector and 4 is the DMA control. Read data is combinational from the current address. An access with the read strobe takes effect at the next clock edge. Reading the vector returns the 1-based position of the lowest pending enabled flag and acknowledges it, so an interrupt handler can service events one at a time by repeated vector reads.

Top module: `irq_vector_unit`

## Requirements
- R1: A synchronous reset, or a cycle with `blockEn` low, clears every status flag, the enable mask and both DMA enables. Event pulses and writes made during that cycle have no effect.
- R2: Each event pulse sets one sticky status bit, read at word 2: NACK bit 1, ARDY bit 2, RRDY bit 3, XRDY bit 4, AAS bit 9, XUDF bit 10, ROVR bit 11, SBD bit 15. Status bit 12 reads the live `busBusy` input and is not stored.
- R3: The enable register (word 1) keeps only write-data bits 4:0. `irqOut` is high exactly when status bits 4:0 ANDed with the enable mask are nonzero.
- R4: A read of the vector (word 3) returns the least significant set bit position of (status AND enable) plus one, or 0 if there is none. A nonzero read clears exactly that one status bit on the same clock edge.
- R5: If an event pulse for a bit arrives in the same cycle as the vector read that clears that bit, the bit stays set.
- R6: The DMA register (word 4) keeps only write-data bits 15 (receive) and 7 (transmit) and reads them back at those positions. `rxDmaReq` equals RRDY while bit 15 is set. `txDmaReq` equals XRDY while bit 7 is set.
- R7: A DMA write with bit 15 set clears enable bit 3. A DMA write with bit 7 set clears enable bit 4. All other enable bits are kept.
- R8: Writes to words 0, 2 and 3 change no state. Word 0 always reads 0x0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blockEn | input | 1 | Module enable; low clears and holds all state |
| busBusy | input | 1 | Live bus-busy level, shown in status bit 12 |
| evNack | input | 1 | Pulse: address or data not acknowledged |
| evArdy | input | 1 | Pulse: access ready |
| evRrdy | input | 1 | Pulse: receive data ready |
| evXrdy | input | 1 | Pulse: transmit data ready |
| evAas | input | 1 | Pulse: addressed as target |
| evXudf | input | 1 | Pulse: transmit underflow |
| evRovr | input | 1 | Pulse: receive overrun |
| evSbd | input | 1 | Pulse: single byte data |
| regAddr | input | 4 | Register word index |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe (vector acknowledge) |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr |
| irqOut | output | 1 | Interrupt request |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |

## Verification
The vector unit is first driven with all eight events pending and a full mask. Successive vector reads must then walk upward through indices 2, 3, 4 and 5 and stop at 0, while the unmasked high flags stay set. A sparse pattern with a partial mask shows that masked-out flags are skipped and never cleared. A set pulse that lands in the same cycle as the acknowledging read shows whether the set takes priority over the clear. DMA writes made while the enables are full show that stripping touches only the two data-ready enables. Writes to the read-only words and a one-cycle drop of the enable input complete the patterns.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int EN_W    = 5;
  localparam int NUM_EVT = 8;
  localparam int VEC_W   = $clog2(EN_W + 1);

  // status bit positions (the vector index depends on them)
  localparam int ST_NACK = 1;
  localparam int ST_ARDY = 2;
  localparam int ST_RRDY = 3;
  localparam int ST_XRDY = 4;
  localparam int ST_AAS  = 9;
  localparam int ST_XUDF = 10;
  localparam int ST_ROVR = 11;
  localparam int ST_BUSY = 12;
  localparam int ST_SBD  = 15;

  localparam int DMA_RX_BIT = 15;
  localparam int DMA_TX_BIT = 7;

  localparam logic [REG_W-1:0] REV_VALUE = 16'h0011;

  localparam logic [ADDR_W-1:0] A_REV  = 4'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_VEC  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DMA  = 4'd4;

  // event pulse order: nack, ardy, rrdy, xrdy, aas, xudf, rovr, sbd
  function automatic int evtPos(input int idx);
    case (idx)
      0: evtPos = ST_NACK;
      1: evtPos = ST_ARDY;
      2: evtPos = ST_RRDY;
      3: evtPos = ST_XRDY;
      4: evtPos = ST_AAS;
      5: evtPos = ST_XUDF;
      6: evtPos = ST_ROVR;
      default: evtPos = ST_SBD;
    endcase
  endfunction

  typedef struct packed {
    logic             clrAll;
    logic             wrEnable;
    logic             wrDma;
    logic             vecAck;
    logic [REG_W-1:0] ackMask;
  } ctrl_strobe_t;
endpackage

// File: rtl/evt_regs.sv
module evt_regs
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               blockEn,
  input  ctrl_strobe_t       stb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_EVT-1:0] evPulse,
  output logic [REG_W-1:0]   statusQ,
  output logic [EN_W-1:0]    enableQ,
  output logic               dmaRxEnQ,
  output logic               dmaTxEnQ,
  output logic               irqOut,
  output logic               rxDmaReq,
  output logic               txDmaReq
);
  logic [REG_W-1:0] setMask;
  logic [EN_W-1:0]  stripMask;

  always_comb begin
    setMask = '0;
    for (int i = 0; i < NUM_EVT; i++) setMask[evtPos(i)] = evPulse[i];
  end

  always_comb begin
    stripMask = '0;
    stripMask[ST_RRDY] = wrData[DMA_RX_BIT];
    stripMask[ST_XRDY] = wrData[DMA_TX_BIT];
  end

  always_ff @(posedge clk) begin
    if (stb.clrAll) begin
      statusQ  <= '0;
      enableQ  <= '0;
      dmaRxEnQ <= 1'b0;
      dmaTxEnQ <= 1'b0;
    end else begin
      // set pulses win over an acknowledge on the same bit
      statusQ <= (statusQ & ~stb.ackMask) | setMask;
      if (stb.wrEnable) enableQ <= wrData[EN_W-1:0];
      else if (stb.wrDma) enableQ <= enableQ & ~stripMask;
      if (stb.wrDma) begin
        dmaRxEnQ <= wrData[DMA_RX_BIT];
        dmaTxEnQ <= wrData[DMA_TX_BIT];
      end
    end
  end

  assign irqOut   = |(statusQ[EN_W-1:0] & enableQ);
  assign rxDmaReq = dmaRxEnQ & statusQ[ST_RRDY];
  assign txDmaReq = dmaTxEnQ & statusQ[ST_XRDY];

  a_r1_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !blockEn |=> (statusQ == '0 && enableQ == '0 && !dmaRxEnQ && !dmaTxEnQ));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (stb.vecAck && blockEn && ((setMask & stb.ackMask) == '0))
      |=> ((statusQ & $past(stb.ackMask)) == '0));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (blockEn && setMask != '0) |=> ((statusQ & $past(setMask)) == $past(setMask)));

  a_r7_rx_strip: assert property (@(posedge clk) disable iff (rst)
    (stb.wrDma && wrData[DMA_RX_BIT]) |=> !enableQ[ST_RRDY]);

  a_r7_tx_strip: assert property (@(posedge clk) disable iff (rst)
    (stb.wrDma && wrData[DMA_TX_BIT]) |=> !enableQ[ST_XRDY]);
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              blockEn,
  input  logic              busBusy,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  statusQ,
  input  logic [EN_W-1:0]   enableQ,
  input  logic              dmaRxEnQ,
  input  logic              dmaTxEnQ,
  output ctrl_strobe_t      stb,
  output logic [REG_W-1:0]  regRdData
);
  logic             active;
  logic [EN_W-1:0]  pending;
  logic [VEC_W-1:0] vecIdx;

  assign active  = blockEn & ~rst;
  assign pending = statusQ[EN_W-1:0] & enableQ;

  always_comb begin
    vecIdx = '0;
    for (int i = EN_W - 1; i >= 0; i--)
      if (pending[i]) vecIdx = VEC_W'(i + 1);
  end

  always_comb begin
    stb          = '0;
    stb.clrAll   = ~active;
    stb.wrEnable = active & regWrEn & (regAddr == A_EN);
    stb.wrDma    = active & regWrEn & (regAddr == A_DMA);
    stb.vecAck   = active & regRdEn & (regAddr == A_VEC) & (vecIdx != '0);
    for (int i = 0; i < EN_W; i++)
      stb.ackMask[i] = stb.vecAck & (vecIdx == VEC_W'(i + 1));
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_REV:  regRdData = REV_VALUE;
      A_EN:   regRdData = REG_W'(enableQ);
      A_STAT: begin
        regRdData = statusQ;
        regRdData[ST_BUSY] = busBusy;
      end
      A_VEC:  regRdData = REG_W'(vecIdx);
      A_DMA:  begin
        regRdData[DMA_RX_BIT] = dmaRxEnQ;
        regRdData[DMA_TX_BIT] = dmaTxEnQ;
      end
      default: regRdData = '0;
    endcase
  end

  a_r4_single_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb.ackMask));

  a_r8_readonly_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && (regAddr == A_REV || regAddr == A_STAT || regAddr == A_VEC))
      |-> (!stb.wrEnable && !stb.wrDma));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              blockEn,
  input  logic              busBusy,
  input  logic              evNack,
  input  logic              evArdy,
  input  logic              evRrdy,
  input  logic              evXrdy,
  input  logic              evAas,
  input  logic              evXudf,
  input  logic              evRovr,
  input  logic              evSbd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqOut,
  output logic              rxDmaReq,
  output logic              txDmaReq
);
  ctrl_strobe_t       stb;
  logic [REG_W-1:0]   statusQ;
  logic [EN_W-1:0]    enableQ;
  logic               dmaRxEnQ;
  logic               dmaTxEnQ;
  logic [NUM_EVT-1:0] evPulse;

  assign evPulse = {evSbd, evRovr, evXudf, evAas, evXrdy, evRrdy, evArdy, evNack};

  evt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .blockEn(blockEn), .busBusy(busBusy),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .statusQ(statusQ), .enableQ(enableQ), .dmaRxEnQ(dmaRxEnQ), .dmaTxEnQ(dmaTxEnQ),
    .stb(stb), .regRdData(regRdData)
  );

  evt_regs u_regs (
    .clk(clk), .rst(rst), .blockEn(blockEn), .stb(stb), .wrData(regWrData),
    .evPulse(evPulse), .statusQ(statusQ), .enableQ(enableQ),
    .dmaRxEnQ(dmaRxEnQ), .dmaTxEnQ(dmaTxEnQ),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );
endmodule

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst, blockEn, busBusy;
  logic [7:0]  ev;
  logic [3:0]  regAddr;
  logic        regWrEn, regRdEn;
  logic [15:0] regWrData, regRdData;
  logic        irqOut, rxDmaReq, txDmaReq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst(rst), .blockEn(blockEn), .busBusy(busBusy),
    .evNack(ev[0]), .evArdy(ev[1]), .evRrdy(ev[2]), .evXrdy(ev[3]),
    .evAas(ev[4]), .evXudf(ev[5]), .evRovr(ev[6]), .evSbd(ev[7]),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    regWrEn = 0; regRdEn = 0; ev = '0;
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1; regRdEn = 0; ev = '0;
    @(negedge clk);
    regWrEn = 0;
  endtask

  // read with optional event pulses in the same cycle
  task automatic regRead(input logic [3:0] a, input logic [7:0] e, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1; regWrEn = 0; ev = e;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 0; ev = '0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    ev = e; regWrEn = 0; regRdEn = 0;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; ev = '0; regWrEn = 0; regRdEn = 0;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic testReset();
    logic [15:0] d;
    doReset();
    regRead(4'd2, 8'h00, d); check("R1 status after reset", d, 16'h0000);
    regRead(4'd1, 8'h00, d); check("R1 enable after reset", d, 16'h0000);
    regRead(4'd4, 8'h00, d); check("R1 dma after reset", d, 16'h0000);
    check("R1 irq after reset", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic testEvents();
    logic [15:0] d;
    doReset();
    pulse(8'hFF);
    busBusy = 1;
    regRead(4'd2, 8'h00, d); check("R2 all events with busy", d, 16'h9E1E);
    busBusy = 0;
    regRead(4'd2, 8'h00, d); check("R2 busy bit live", d, 16'h8E1E);
    check("R3 irq masked off", {15'b0, irqOut}, 16'h0000);
    regWrite(4'd1, 16'hFFFF);
    regRead(4'd1, 8'h00, d); check("R3 enable width", d, 16'h001F);
    check("R3 irq raised", {15'b0, irqOut}, 16'h0001);
  endtask

  task automatic testVectorWalk();
    logic [15:0] d;
    regRead(4'd3, 8'h00, d); check("R4 vector nack", d, 16'd2);
    regRead(4'd2, 8'h00, d); check("R4 only nack cleared", d, 16'h8E1C);
    regRead(4'd3, 8'h00, d); check("R4 vector ardy", d, 16'd3);
    regRead(4'd3, 8'h00, d); check("R4 vector rrdy", d, 16'd4);
    regRead(4'd3, 8'h00, d); check("R4 vector xrdy", d, 16'd5);
    regRead(4'd3, 8'h00, d); check("R4 vector none", d, 16'd0);
    regRead(4'd2, 8'h00, d); check("R4 high flags kept", d, 16'h8E00);
    check("R3 irq dropped", {15'b0, irqOut}, 16'h0000);
  endtask

  task automatic testSparse();
    logic [15:0] d;
    doReset();
    pulse(8'h0E);            // ardy, rrdy, xrdy
    regWrite(4'd1, 16'h0014); // enable bits 2 and 4
    regRead(4'd3, 8'h00, d); check("R4 sparse first", d, 16'd3);
    regRead(4'd3, 8'h00, d); check("R4 sparse second", d, 16'd5);
    regRead(4'd3, 8'h00, d); check("R4 sparse none", d, 16'd0);
    regRead(4'd2, 8'h00, d); check("R4 masked flag kept", d, 16'h0008);
  endtask

  task automatic testSetWins();
    logic [15:0] d;
    doReset();
    regWrite(4'd1, 16'h001F);
    pulse(8'h01);
    regRead(4'd3, 8'h01, d); check("R5 vector with same pulse", d, 16'd2);
    regRead(4'd2, 8'h00, d); check("R5 nack survives", d, 16'h0002);
    regRead(4'd3, 8'h00, d); check("R5 second ack", d, 16'd2);
    regRead(4'd3, 8'h00, d); check("R5 then empty", d, 16'd0);
  endtask

  task automatic testDma();
    logic [15:0] d;
    doReset();
    regWrite(4'd4, 16'hFFFF);
    regRead(4'd4, 8'h00, d); check("R6 dma keeps two bits", d, 16'h8080);
    pulse(8'h04);
    check("R6 rx req follows rrdy", {14'b0, rxDmaReq, txDmaReq}, 16'h0002);
    pulse(8'h08);
    check("R6 both reqs", {14'b0, rxDmaReq, txDmaReq}, 16'h0003);
    regWrite(4'd4, 16'h0080);
    check("R6 rx disabled", {14'b0, rxDmaReq, txDmaReq}, 16'h0001);
  endtask

  task automatic testStrip();
    logic [15:0] d;
    doReset();
    regWrite(4'd1, 16'h001F);
    regWrite(4'd4, 16'h8000);
    regRead(4'd1, 8'h00, d); check("R7 rx strips bit3", d, 16'h0017);
    regWrite(4'd4, 16'h0080);
    regRead(4'd1, 8'h00, d); check("R7 tx strips bit4", d, 16'h0007);
  endtask

  task automatic testReadOnly();
    logic [15:0] d;
    doReset();
    regWrite(4'd1, 16'h0003);
    pulse(8'h02);
    regWrite(4'd0, 16'hFFFF);
    regWrite(4'd2, 16'hFFFF);
    regWrite(4'd3, 16'hFFFF);
    regRead(4'd0, 8'h00, d); check("R8 revision", d, 16'h0011);
    regRead(4'd2, 8'h00, d); check("R8 status untouched", d, 16'h0004);
    regRead(4'd1, 8'h00, d); check("R8 enable untouched", d, 16'h0003);
    regRead(4'd4, 8'h00, d); check("R8 dma untouched", d, 16'h0000);
  endtask

  task automatic testDisable();
    logic [15:0] d;
    doReset();
    regWrite(4'd1, 16'h001F);
    regWrite(4'd4, 16'h0080);
    pulse(8'hFF);
    @(negedge clk);
    blockEn = 0; ev = 8'hFF;
    @(negedge clk);
    blockEn = 1; ev = '0;
    regRead(4'd2, 8'h00, d); check("R1 disable clears status", d, 16'h0000);
    regRead(4'd1, 8'h00, d); check("R1 disable clears enable", d, 16'h0000);
    regRead(4'd4, 8'h00, d); check("R1 disable clears dma", d, 16'h0000);
    check("R1 irq low after disable", {15'b0, irqOut}, 16'h0000);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; blockEn = 1; busBusy = 0; ev = '0;
    regAddr = '0; regWrEn = 0; regRdEn = 0; regWrData = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    testReset();
    testEvents();
    testVectorWalk();
    testSparse();
    testSetWins();
    testDma();
    testStrip();
    testReadOnly();
    testDisable();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule